// File: doc/BRIEF.md
# Supervisor Interrupt Pending View

This block holds the machine-level pending state for four interrupt sources: supervisor software, supervisor timer, supervisor external and local counter overflow. It serves two windows onto that state through one CSR port. The machine window shows every pending bit, including the hypervisor-level bits supplied from outside. The supervisor window is a narrower view: each of the four bits shows only while the matching bit of the delegation mask is set, and each bit follows its own write rule in that window.

Hardware sources set and clear the timer, external and overflow bits. The live external interrupt line is OR-ed into the external bit that software reads. The complete machine pending vector is driven out on every cycle for the interrupt arbiter.

Top module: `irq_pend_csr`

## Requirements
- R1: The supervisor window is at CSR address 0x144 and the machine window at 0x344, both 64 bits wide. The pending bits sit at bit 1 (software), bit 5 (timer), bit 9 (external) and bit 13 (overflow). Every other bit of the supervisor window reads 0.
- R2: In the supervisor window, a source whose delegation bit (at the same bit position) is 0 reads 0.
- R3: A supervisor write leaves a source unchanged when that source's delegation bit is 0. The machine window shows this.
- R4: When delegated, a supervisor write sets the software bit to the written value. The new value shows in both windows from the next cycle.
- R5: Supervisor writes never change the timer or external bit. Hardware set and clear inputs drive those bits: set wins over clear, and clear wins over a software write.
- R6: When delegated, a supervisor write of 0 to the overflow bit clears it, and a write of 1 sets it.
- R7: A hardware overflow set in the same cycle as any software write to the overflow bit leaves the bit at 1.
- R8: The hypervisor-level bits 2, 6, 10 and 12 come from the hv_pend input. They show in the machine window and in pend_out, and never in the supervisor window.
- R9: The external bit that is read equals the stored bit OR ext_line. Software writes change only the stored bit.
- R10: A machine-window write sets the software, timer, external and overflow bits to the written values, whatever the delegation mask holds.
- R11: All stored bits reset to 0. csr_rdata is 0 when csr_re is low or the address matches neither window. A write to any other address changes nothing.
- R12: pend_out always equals the machine window contents, and a machine-window read returns pend_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_re | input | 1 | Read enable |
| csr_we | input | 1 | Write enable |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, combinational |
| deleg_mask | input | 64 | Machine delegation mask |
| hw_tmr_set | input | 1 | Timer pending set |
| hw_tmr_clr | input | 1 | Timer pending clear |
| hw_ext_set | input | 1 | External pending set (stored bit) |
| hw_ext_clr | input | 1 | External pending clear (stored bit) |
| hw_ovf_set | input | 1 | Counter overflow pending set |
| ext_line | input | 1 | Live external interrupt line |
| hv_pend | input | 64 | Hypervisor-level pending bits (2, 6, 10, 12 used) |
| pend_out | output | 64 | Full machine pending vector to the arbiter |

## Verification
On every cycle, the assertions check the following:
- the supervisor window stays clean: no undelegated bit and no hypervisor bit ever shows in it;
- a supervisor write never moves the timer bit;
- the overflow set wins over a software write;
- the live external line always reaches pend_out;
- reads of other addresses return zero.

Some behaviour needs scenarios and a reference model: the exact value after a write through each window, the ordering of hardware set and clear, and the fact that an ignored write leaves nothing behind. For these, the bench compares both read data and pend_out with the model under random traffic and directed corner cases.

// File: rtl/irq_pend_pkg.sv
`timescale 1ns/1ps
package irq_pend_pkg;
  localparam int XLEN   = 64;
  localparam int ADDR_W = 12;
  localparam int NSRC   = 4;

  localparam logic [ADDR_W-1:0] SUP_ADDR = 12'h144;
  localparam logic [ADDR_W-1:0] MCH_ADDR = 12'h344;

  // source index -> bit position in both windows
  localparam int SRC_POS [NSRC] = '{1, 5, 9, 13};
  localparam int IDX_SW  = 0;
  localparam int IDX_TMR = 1;
  localparam int IDX_EXT = 2;
  localparam int IDX_OVF = 3;

  // writable from the supervisor window when delegated
  localparam logic [NSRC-1:0] SUP_WRITABLE = 4'b1001;
  // sources with hardware set/clear
  localparam logic [NSRC-1:0] HAS_HW_SRC   = 4'b1110;

  localparam logic [XLEN-1:0] HV_MASK =
    (64'd1 << 2) | (64'd1 << 6) | (64'd1 << 10) | (64'd1 << 12);

  function automatic logic [NSRC-1:0] gather(input logic [XLEN-1:0] w);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = w[SRC_POS[i]];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] scatter(input logic [NSRC-1:0] v);
    logic [XLEN-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) r[SRC_POS[i]] = v[i];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] sup_mask(input logic [XLEN-1:0] deleg);
    return scatter(gather(deleg));
  endfunction
endpackage

// File: rtl/irq_csr_decode.sv
`timescale 1ns/1ps
module irq_csr_decode
  import irq_pend_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              s_hit,
  output logic              m_hit,
  output logic              s_wr,
  output logic              m_wr
);
  always_comb begin
    s_hit = (addr == SUP_ADDR);
    m_hit = (addr == MCH_ADDR);
    s_wr  = we && s_hit;
    m_wr  = we && m_hit;
  end
endmodule

// File: rtl/irq_pend_bit.sv
`timescale 1ns/1ps
module irq_pend_bit #(
  parameter bit HAS_HW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic sw_we,
  input  logic sw_val,
  output logic q
);
  logic nxt;

  // priority: hardware set, hardware clear, software write
  always_comb begin
    nxt = q;
    if (sw_we)             nxt = sw_val;
    if (HAS_HW && hw_clr)  nxt = 1'b0;
    if (HAS_HW && hw_set)  nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/irq_rd_mux.sv
`timescale 1ns/1ps
module irq_rd_mux
  import irq_pend_pkg::*;
(
  input  logic            re,
  input  logic            s_hit,
  input  logic            m_hit,
  input  logic [XLEN-1:0] m_view,
  input  logic [XLEN-1:0] s_gate,
  output logic [XLEN-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (re && s_hit)      rdata = m_view & s_gate;
    else if (re && m_hit) rdata = m_view;
  end
endmodule

// File: rtl/irq_pend_csr.sv
`timescale 1ns/1ps
module irq_pend_csr
  import irq_pend_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic              csr_re,
  input  logic              csr_we,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic [XLEN-1:0]   deleg_mask,
  input  logic              hw_tmr_set,
  input  logic              hw_tmr_clr,
  input  logic              hw_ext_set,
  input  logic              hw_ext_clr,
  input  logic              hw_ovf_set,
  input  logic              ext_line,
  input  logic [XLEN-1:0]   hv_pend,
  output logic [XLEN-1:0]   pend_out
);
  logic s_hit, m_hit, s_wr, m_wr;
  logic [NSRC-1:0] src_q, bit_we, wval, deleg4, hw_set, hw_clr, live;
  logic [XLEN-1:0] m_view, s_gate;

  irq_csr_decode u_dec (
    .addr (csr_addr), .we (csr_we),
    .s_hit(s_hit), .m_hit(m_hit), .s_wr(s_wr), .m_wr(m_wr)
  );

  always_comb begin
    deleg4 = gather(deleg_mask);
    wval   = gather(csr_wdata);
    hw_set = '0;
    hw_clr = '0;
    hw_set[IDX_TMR] = hw_tmr_set;
    hw_clr[IDX_TMR] = hw_tmr_clr;
    hw_set[IDX_EXT] = hw_ext_set;
    hw_clr[IDX_EXT] = hw_ext_clr;
    hw_set[IDX_OVF] = hw_ovf_set;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign bit_we[i] = m_wr || (s_wr && SUP_WRITABLE[i] && deleg4[i]);
    irq_pend_bit #(.HAS_HW(HAS_HW_SRC[i])) u_bit (
      .clk(clk), .rst_n(rst_n),
      .hw_set(hw_set[i]), .hw_clr(hw_clr[i]),
      .sw_we(bit_we[i]), .sw_val(wval[i]),
      .q(src_q[i])
    );
  end

  always_comb begin
    live = src_q;
    live[IDX_EXT] = src_q[IDX_EXT] | ext_line;
    m_view = scatter(live) | (hv_pend & HV_MASK);
    s_gate = sup_mask(deleg_mask);
  end

  assign pend_out = m_view;

  irq_rd_mux u_rd (
    .re(csr_re), .s_hit(s_hit), .m_hit(m_hit),
    .m_view(m_view), .s_gate(s_gate), .rdata(csr_rdata)
  );
endmodule

// File: rtl/irq_pend_csr_chk.sv
`timescale 1ns/1ps
module irq_pend_csr_chk
  import irq_pend_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              csr_re,
  input logic [XLEN-1:0]   csr_wdata,
  input logic [XLEN-1:0]   csr_rdata,
  input logic [XLEN-1:0]   deleg_mask,
  input logic              hw_tmr_set,
  input logic              hw_tmr_clr,
  input logic              hw_ovf_set,
  input logic              ext_line,
  input logic [XLEN-1:0]   pend_out,
  input logic              s_wr,
  input logic              m_wr
);
  localparam logic [XLEN-1:0] S_BITS =
    (64'd1 << 1) | (64'd1 << 5) | (64'd1 << 9) | (64'd1 << 13);

  p_sview_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_re && csr_addr == SUP_ADDR) |-> ((csr_rdata & ~S_BITS) == '0));

  p_undeleg_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_re && csr_addr == SUP_ADDR) |-> ((csr_rdata & ~deleg_mask) == '0));

  p_undeleg_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr && !deleg_mask[1] && !m_wr) |=> (pend_out[1] == $past(pend_out[1])));

  p_ssip_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr && deleg_mask[1]) |=> (pend_out[1] == $past(csr_wdata[1])));

  p_timer_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_wr && !hw_tmr_set && !hw_tmr_clr) |=> (pend_out[5] == $past(pend_out[5])));

  p_ovf_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ovf_set |=> pend_out[13]);

  p_hv_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_re && csr_addr == SUP_ADDR) |-> ((csr_rdata & HV_MASK) == '0));

  p_ext_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ext_line |-> pend_out[9]);

  p_unrelated_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr != SUP_ADDR && csr_addr != MCH_ADDR) |-> (csr_rdata == '0));

  p_mview_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_re && csr_addr == MCH_ADDR) |-> (csr_rdata == pend_out));
endmodule

bind irq_pend_csr irq_pend_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_re(csr_re),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .deleg_mask(deleg_mask),
  .hw_tmr_set(hw_tmr_set), .hw_tmr_clr(hw_tmr_clr), .hw_ovf_set(hw_ovf_set),
  .ext_line(ext_line), .pend_out(pend_out), .s_wr(s_wr), .m_wr(m_wr)
);

// File: tb/test_irq_pend_csr.sv
`timescale 1ns/1ps
module test_irq_pend_csr;
  localparam logic [11:0] SA = 12'h144;
  localparam logic [11:0] MA = 12'h344;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] a_addr = '0;
  logic a_re = 1'b0, a_we = 1'b0;
  logic [63:0] a_wd = '0, a_deleg = '0, a_hv = '0;
  logic t_set = 0, t_clr = 0, e_set = 0, e_clr = 0, o_set = 0, e_line = 0;
  logic [63:0] rdata, pout;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  logic m_ss = 0, m_st = 0, m_se = 0, m_lc = 0;

  always #2.5 clk = ~clk;

  irq_pend_csr i_irq_pend_csr (
    .clk(clk), .rst_n(rst_n), .csr_addr(a_addr), .csr_re(a_re), .csr_we(a_we),
    .csr_wdata(a_wd), .csr_rdata(rdata), .deleg_mask(a_deleg),
    .hw_tmr_set(t_set), .hw_tmr_clr(t_clr), .hw_ext_set(e_set), .hw_ext_clr(e_clr),
    .hw_ovf_set(o_set), .ext_line(e_line), .hv_pend(a_hv), .pend_out(pout)
  );

  function automatic logic [63:0] exp_mview();
    logic [63:0] v = '0;
    v[1]  = m_ss;
    v[5]  = m_st;
    v[9]  = m_se | e_line;
    v[13] = m_lc;
    v[2] = a_hv[2]; v[6] = a_hv[6]; v[10] = a_hv[10]; v[12] = a_hv[12];
    return v;
  endfunction

  function automatic logic [63:0] exp_rdata();
    logic [63:0] m = exp_mview();
    logic [63:0] s = '0;
    if (!a_re) return '0;
    if (a_addr == MA) return m;
    if (a_addr != SA) return '0;
    foreach (s[k]) if ((k == 1 || k == 5 || k == 9 || k == 13) && a_deleg[k]) s[k] = m[k];
    return s;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called just after a negedge with inputs driven; checks, then advances one cycle
  task automatic step(string tag);
    bit sw, mw;
    #1;
    chk({tag, " rdata"}, rdata, exp_rdata());
    chk({"R12 pend_out ", tag}, pout, exp_mview());
    @(posedge clk);
    if (!rst_n) begin
      m_ss = 0; m_st = 0; m_se = 0; m_lc = 0;
    end else begin
      sw = a_we && a_addr == SA;
      mw = a_we && a_addr == MA;
      if (mw || (sw && a_deleg[1])) m_ss = a_wd[1];
      if (t_set) m_st = 1; else if (t_clr) m_st = 0; else if (mw) m_st = a_wd[5];
      if (e_set) m_se = 1; else if (e_clr) m_se = 0; else if (mw) m_se = a_wd[9];
      if (o_set) m_lc = 1; else if (mw || (sw && a_deleg[13])) m_lc = a_wd[13];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    a_re = 0; a_we = 0; a_wd = '0;
    t_set = 0; t_clr = 0; e_set = 0; e_clr = 0; o_set = 0;
  endtask

  task automatic rd(logic [11:0] ad, string tag);
    idle(); a_addr = ad; a_re = 1; step(tag);
  endtask

  task automatic wr(logic [11:0] ad, logic [63:0] d, string tag);
    idle(); a_addr = ad; a_we = 1; a_wd = d; step(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed1234));
    @(negedge clk);
    step("R11 in reset");
    step("R11 in reset");
    rst_n = 1;
    rd(MA, "R11 reset state M");
    chk("R11 reset value", rdata, 64'd0);

    // undelegated writes ignored
    a_deleg = '0;
    wr(SA, '1, "R3 undelegated S write");
    rd(MA, "R3 M after undelegated write");
    rd(SA, "R2 undelegated read");

    // software bit alias
    a_deleg = 64'h2222;
    wr(SA, 64'h2, "R4 S write ssip");
    rd(MA, "R4 M shows ssip");
    rd(SA, "R4 S shows ssip");

    // timer read-only, hw priority
    idle(); t_set = 1; a_addr = SA; a_we = 1; a_wd = '0; step("R5 tmr set with S write");
    wr(SA, '0, "R5 S write timer ignored");
    idle(); t_set = 1; t_clr = 1; step("R5 set beats clear");
    idle(); t_clr = 1; a_addr = MA; a_we = 1; a_wd = '1; step("R5 clear beats M write");
    rd(SA, "R5 S mirror");

    // overflow clear and race
    idle(); o_set = 1; step("R6 ovf hw set");
    wr(SA, '0, "R6 S write 0 clears ovf");
    rd(SA, "R6 ovf cleared");
    idle(); o_set = 1; a_addr = SA; a_we = 1; a_wd = '0; step("R7 set with write 0");
    rd(SA, "R7 ovf stays set");
    chk("R7 ovf bit", rdata[13], 1'b1);

    // hypervisor bits
    a_hv = '1;
    rd(SA, "R8 hv hidden in S");
    rd(MA, "R8 hv shown in M");
    a_hv = '0;

    // external OR
    e_line = 1;
    wr(MA, '0, "R9 M write 0 with line high");
    rd(MA, "R9 line keeps ext");
    e_line = 0;
    rd(MA, "R9 stored bit cleared");

    // machine window ignores delegation
    a_deleg = '0;
    wr(MA, 64'h2222, "R10 M write all");
    rd(MA, "R10 M readback");
    rd(SA, "R1 S window with no delegation");
    a_deleg = '1;
    rd(SA, "R1 S window full delegation");

    // unrelated address
    wr(12'h145, '0, "R11 unrelated write");
    rd(12'h145, "R11 unrelated read");
    rd(MA, "R11 state unchanged");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int sel = $urandom_range(0, 9);
      a_addr = (sel < 4) ? SA : (sel < 8) ? MA : 12'($urandom);
      a_re = 1'($urandom);
      a_we = ($urandom_range(0, 2) == 0);
      a_wd = {$urandom, $urandom};
      if ($urandom_range(0, 15) == 0) a_deleg = {$urandom, $urandom};
      if ($urandom_range(0, 15) == 0) a_hv = {$urandom, $urandom};
      t_set = ($urandom_range(0, 7) == 0);
      t_clr = ($urandom_range(0, 7) == 0);
      e_set = ($urandom_range(0, 7) == 0);
      e_clr = ($urandom_range(0, 7) == 0);
      o_set = ($urandom_range(0, 7) == 0);
      e_line = ($urandom_range(0, 5) == 0);
      step("R1 R2 R5 R6 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule